// File: doc/BRIEF.md
# Board Interrupt-Level Encoder with Control Registers

This block gathers thirteen level-sensitive interrupt lines from on-board peripherals and reduces them to one 4-bit priority code for the processor. Each line has a fixed priority level from 0 to 12, where a lower number wins. Each line also has a fixed bit position in a 16-bit status word, and that position does not follow the level order. A software-writable enable word selects which status bits may compete. The winning level is sent out inverted, so an all-zero bus means that nothing is requesting service.

The same block decodes a 64-byte window on a simple synchronous bus. The window holds four 16-bit locations:
- the enable word;
- a general-purpose output latch whose value also drives pins;
- a power-off control location that only produces a one-cycle shutdown strobe;
- a read-only identification value.

Top module: `brd_intlvl_ctrl`

## Requirements
- R1: After reset the enable word and the output latch are 0, `lvl_n_o` is 0 and `shutdown_req_o` is low, so every source is disabled.
- R2: Input `irq_src_i[k]` has priority level k. Its status bit position is, for k = 0..12 in order: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. The selected level is the smallest k whose input is high and whose status bit is set in the enable word.
- R3: `lvl_n_o` carries the selected level XOR 4'hF. When no source qualifies, the selected level is 15 and `lvl_n_o` is 4'h0. A winning level 0 is driven as 4'hF.
- R4: `lvl_n_o` is registered. It reflects the inputs sampled at the previous rising edge, together with the enable word as it stood before that edge. A write to the enable word therefore shows on the output one edge after the write edge.
- R5: Byte offset 0x00 reads and writes the enable word. All 16 bits are stored, and bits 1, 2 and 3 have no effect on selection.
- R6: Offset 0x36 is a 16-bit read/write latch, and its stored value drives `gpo_o`.
- R7: Offset 0x30 reads 0. A write there with bit 0 set makes `shutdown_req_o` high for exactly the cycle after the write edge. A write with bit 0 clear produces no strobe.
- R8: Offset 0x32 always reads 16'h0010. Writes to it change no register.
- R9: Reads of any other offset return 0. Writes to any other offset change neither the enable word nor the output latch.
- R10: `bus_rdata_o` is combinational from `bus_addr_i` while `bus_sel_i` is high and `bus_wr_i` is low, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 13 | Interrupt request levels; index equals priority level |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset inside the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| lvl_n_o | output | 4 | Inverted winning priority level |
| gpo_o | output | 16 | General-purpose output latch |
| shutdown_req_o | output | 1 | One-cycle power-off request strobe |

## Verification
The assertions check several rules on every cycle:
- the bus idles at zero when no enabled source is pending;
- the top-priority source forces 4'hF;
- a strobe is always traced back to a qualifying power-off write;
- the version read value never changes;
- the two stored registers change only under a write to their own offset.

Only the bench's scenarios can show the rest:
- that the scattered bit table and the minimum-level search are right for arbitrary mixtures of active inputs;
- that a write to the enable word lands exactly one edge late on the output;
- that unmapped offsets stay silent on both reads and writes.

// File: rtl/intlvl_pkg.sv
package intlvl_pkg;

    localparam int NUM_SRC  = 13;
    localparam int LVL_W    = 4;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 6;
    localparam int BITPOS_W = $clog2(DATA_W);

    localparam logic [LVL_W-1:0]  IDLE_LVL   = '1;
    localparam logic [DATA_W-1:0] VERSION_ID = 16'h0010;

    localparam logic [ADDR_W-1:0] OFF_ENABLE  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_POWER   = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_VERSION = 6'h32;
    localparam logic [ADDR_W-1:0] OFF_GPO     = 6'h36;

    typedef logic [BITPOS_W-1:0] bitpos_t;

    // Status-word position owned by the source of a given priority level.
    function automatic bitpos_t src_bit(input int lvl);
        unique case (lvl)
            0:       return bitpos_t'(11);
            1:       return bitpos_t'(9);
            2:       return bitpos_t'(8);
            3:       return bitpos_t'(12);
            4:       return bitpos_t'(10);
            5:       return bitpos_t'(6);
            6:       return bitpos_t'(5);
            7:       return bitpos_t'(4);
            8:       return bitpos_t'(7);
            9:       return bitpos_t'(14);
            10:      return bitpos_t'(13);
            11:      return bitpos_t'(0);
            default: return bitpos_t'(15);
        endcase
    endfunction

endpackage

// File: rtl/intlvl_map.sv
module intlvl_map
    import intlvl_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_i,
    output logic [DATA_W-1:0]  status_o
);

    // The status word follows the input levels directly; unmapped bits stay 0.
    always_comb begin
        status_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            status_o[src_bit(k)] = src_i[k];
        end
    end

endmodule

// File: rtl/intlvl_pick.sv
module intlvl_pick
    import intlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic [LVL_W-1:0]  lvl_n_o
);

    logic [DATA_W-1:0] qual;
    logic [LVL_W-1:0]  best;
    logic [LVL_W-1:0]  lvl_n_q;

    assign qual = status_i & enable_i;

    // Walk from the weakest level toward level 0 so the lowest qualifier wins.
    always_comb begin
        best = IDLE_LVL;
        for (int l = NUM_SRC - 1; l >= 0; l--) begin
            if (qual[src_bit(l)]) begin
                best = LVL_W'(l);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_n_q <= '0;
        end else begin
            lvl_n_q <= best ^ IDLE_LVL;
        end
    end

    assign lvl_n_o = lvl_n_q;

    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (qual == '0) |=> (lvl_n_o == '0));

    assert_top_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        qual[src_bit(0)] |=> (lvl_n_o == IDLE_LVL));

endmodule

// File: rtl/intlvl_regs.sv
module intlvl_regs
    import intlvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] enable_o,
    output logic [DATA_W-1:0] gpo_o,
    output logic              shutdown_o
);

    logic [DATA_W-1:0] enable_q;
    logic [DATA_W-1:0] gpo_q;
    logic              shut_q;
    logic              wr_en;
    logic              rd_en;

    assign wr_en = sel_i & wr_i;
    assign rd_en = sel_i & ~wr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            gpo_q    <= '0;
            shut_q   <= 1'b0;
        end else begin
            shut_q <= wr_en && (addr_i == OFF_POWER) && wdata_i[0];
            if (wr_en && addr_i == OFF_ENABLE) enable_q <= wdata_i;
            if (wr_en && addr_i == OFF_GPO)    gpo_q    <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_en) begin
            unique case (addr_i)
                OFF_ENABLE:  rdata_o = enable_q;
                OFF_GPO:     rdata_o = gpo_q;
                OFF_VERSION: rdata_o = VERSION_ID;
                default:     rdata_o = '0;
            endcase
        end
    end

    assign enable_o   = enable_q;
    assign gpo_o      = gpo_q;
    assign shutdown_o = shut_q;

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_i == OFF_ENABLE) |=> $stable(enable_o));

    assert_gpo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_i == OFF_GPO) |=> $stable(gpo_o));

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_o |-> $past(sel_i && wr_i && addr_i == OFF_POWER && wdata_i[0]));

    assert_version_const_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_i == OFF_VERSION) |-> (rdata_o == VERSION_ID));

endmodule

// File: rtl/brd_intlvl_ctrl.sv
module brd_intlvl_ctrl
    import intlvl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src_i,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [LVL_W-1:0]   lvl_n_o,
    output logic [DATA_W-1:0]  gpo_o,
    output logic               shutdown_req_o
);

    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] enable_w;

    intlvl_map map_i (
        .src_i    (irq_src_i),
        .status_o (status_w)
    );

    intlvl_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .enable_o   (enable_w),
        .gpo_o      (gpo_o),
        .shutdown_o (shutdown_req_o)
    );

    intlvl_pick pick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_w),
        .enable_i (enable_w),
        .lvl_n_o  (lvl_n_o)
    );

    assert_no_strobe_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_wr_i) |=> !shutdown_req_o);

endmodule

// File: tb/brd_intlvl_ctrl_tb.sv
module brd_intlvl_ctrl_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] irq_src_i = '0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [5:0]  bus_addr_i = '0;
    logic [15:0] bus_wdata_i = '0;
    logic [15:0] bus_rdata_o;
    logic [3:0]  lvl_n_o;
    logic [15:0] gpo_o;
    logic        shutdown_req_o;

    int vectors = 0;
    int misses  = 0;

    // Reference state
    int m_enable = 0;
    int m_gpo = 0;
    int m_lvl_n = 0;
    int m_shut = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brd_intlvl_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_src_i      (irq_src_i),
        .bus_sel_i      (bus_sel_i),
        .bus_wr_i       (bus_wr_i),
        .bus_addr_i     (bus_addr_i),
        .bus_wdata_i    (bus_wdata_i),
        .bus_rdata_o    (bus_rdata_o),
        .lvl_n_o        (lvl_n_o),
        .gpo_o          (gpo_o),
        .shutdown_req_o (shutdown_req_o)
    );

    function automatic int pos_of(int lvl);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[lvl];
    endfunction

    function automatic int ref_level(int src, int en);
        for (int l = 0; l < 13; l++) begin
            if (((src >> l) & 1) != 0 && ((en >> pos_of(l)) & 1) != 0) return l;
        end
        return 15;
    endfunction

    function automatic int ref_read(int a);
        case (a)
            'h00:    return m_enable;
            'h36:    return m_gpo;
            'h32:    return 'h10;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model with the pre-edge inputs, then compare after the edge.
    task automatic tick(string req);
        @(posedge clk);
        m_lvl_n = ref_level(int'(irq_src_i), m_enable) ^ 15;
        m_shut  = (bus_sel_i && bus_wr_i && bus_addr_i == 6'h30 && bus_wdata_i[0]) ? 1 : 0;
        if (bus_sel_i && bus_wr_i) begin
            if (bus_addr_i == 6'h00) m_enable = int'(bus_wdata_i);
            if (bus_addr_i == 6'h36) m_gpo    = int'(bus_wdata_i);
        end
        @(negedge clk);
        check({req, " lvl R2/R3/R4"}, int'(lvl_n_o), m_lvl_n);
        check("R7 strobe", int'(shutdown_req_o), m_shut);
        check("R6 gpo", int'(gpo_o), m_gpo);
        bus_sel_i = 1'b0;
        bus_wr_i  = 1'b0;
    endtask

    task automatic bus_write(logic [5:0] a, logic [15:0] d, string req);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        tick(req);
    endtask

    task automatic bus_read(logic [5:0] a, string req);
        bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
        #1;
        check(req, int'(bus_rdata_o), ref_read(int'(a)));
        tick(req);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset values
        check("R1 lvl", int'(lvl_n_o), 0);
        check("R1 gpo", int'(gpo_o), 0);
        check("R1 strobe", int'(shutdown_req_o), 0);
        bus_read(6'h00, "R1 enable");

        // All sources active but masked: idle output (R3)
        irq_src_i = '1;
        tick("R3 masked");
        // R4: enable write takes effect one edge later
        bus_write(6'h00, 16'hFFFF, "R4 write");
        tick("R4 after");
        check("R2 top level", int'(lvl_n_o), 15);
        // Each source alone (R2)
        for (int k = 0; k < 13; k++) begin
            irq_src_i = 13'(1 << k);
            tick("R2 single");
            check("R2 single lvl", int'(lvl_n_o), k ^ 15);
        end
        // R5: bits 1..3 only -> nothing selected
        bus_write(6'h00, 16'h000E, "R5 unmapped bits");
        irq_src_i = '1;
        tick("R5");
        check("R5 no effect", int'(lvl_n_o), 0);
        bus_read(6'h00, "R5 readback");

        // R6 output latch
        bus_write(6'h36, 16'hA5C3, "R6 write");
        bus_read(6'h36, "R6 readback");
        // R7 power location
        bus_write(6'h30, 16'h0001, "R7 strobe");
        tick("R7 single pulse");
        bus_write(6'h30, 16'hFFFE, "R7 bit0 clear");
        bus_read(6'h30, "R7 read zero");
        // R8 version
        bus_write(6'h32, 16'h1234, "R8 write ignored");
        bus_read(6'h32, "R8 read");
        bus_read(6'h36, "R8 no side effect");
        // R9 other offsets
        bus_write(6'h02, 16'h5555, "R9 write ignored");
        bus_write(6'h3E, 16'h7777, "R9 write ignored");
        bus_read(6'h02, "R9 read zero");
        bus_read(6'h3E, "R9 read zero");
        bus_read(6'h00, "R9 enable kept");
        // R10: write cycle drives zero read data
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 6'h32; bus_wdata_i = 16'h0;
        #1;
        check("R10 rdata during write", int'(bus_rdata_o), 0);
        tick("R10");

        // Random mixtures of inputs and enable writes
        for (int n = 0; n < 400; n++) begin
            irq_src_i = 13'($urandom);
            if ($urandom_range(0, 3) == 0)
                bus_write(6'h00, 16'($urandom), "R2 random enable");
            else
                tick("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule